// File: doc/BRIEF.md
# UART Interrupt and FIFO Status Unit

This block sits between a UART's serial engines and the host bus. It holds a receive FIFO and a transmit FIFO. It tags every received character with break, parity and framing flags. From the state of the two FIFOs it derives a small set of interrupt sources, and each source has its own mask bit. The serial receiver pushes characters in, and the serial transmitter pulls characters out. The host reads received words, writes characters to send, programs the mask and the thresholds, and resets either FIFO on its own.

There are three receive sources. The first is an overrun, which stays set until the receive FIFO is reset. The second is a fill level above a programmed level. The third is data left unread for a programmed number of character times; the character time is marked by a strobe from the baud logic outside the block. There are two transmit sources: an empty FIFO, and a fill level below a programmed level. The transmit fill count is an output, so software can work out the free space as depth minus fill. The interrupt line is the OR of the masked sources.

Top module: `uart_irq_fifo_unit`

## Requirements
- R1: After reset both FIFOs are empty, `tx_fill` is 0, the mask reads 0, the overrun status is 0 and `irq` is low.
- R2: `host_rdata` shows the oldest received entry with bit DW+3 = valid, DW+2 = break, DW+1 = parity error, DW = framing error and DW-1:0 = character. A `host_rd` strobe removes that entry, so entries come out in arrival order. While the receive FIFO is empty, `host_rdata` is all zero.
- R3: A character pushed while the receive FIFO is full, with no read in the same cycle, is discarded and sets status bit 0 (overrun). Reads do not clear that bit. Only `rx_fifo_clr` clears it.
- R4: Status bit 1 is set exactly while the receive fill is greater than `rx_level`.
- R5: Status bit 2 is set while the receive FIFO is non-empty, `idle_chars` is non-zero, and at least `idle_chars` pulses of `char_tick` have arrived since the last push into the receive FIFO or read from it. A value of 0 in `idle_chars` disables this source.
- R6: Status bit 3 is set exactly while the transmit FIFO is empty, and `tx_ready` is its inverse. Status bit 4 is set exactly while `tx_fill` is less than `tx_level`.
- R7: `tx_fill` counts the characters held for transmission. A host write into a full transmit FIFO is discarded. `tx_pop` hands characters to `tx_char` in write order.
- R8: Status bit 5 reports that the receive FIFO is not empty. It has no mask bit.
- R9: A `mask_wr` strobe loads `mask_wdata` into `irq_mask`. Bit i of the mask gates source i for i = 0..4, and `irq` is the OR of `irq_status[4:0] & irq_mask`.
- R10: `rx_fifo_clr` empties only the receive FIFO, and `tx_fifo_clr` empties only the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_tick | input | 1 | One pulse per character time |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | DW | Received character |
| rx_brk | input | 1 | Break seen on this character |
| rx_par_err | input | 1 | Parity error on this character |
| rx_frm_err | input | 1 | Framing error on this character |
| host_rd | input | 1 | Host consumes the shown receive entry |
| host_rdata | output | DW+4 | Oldest receive entry with flags |
| host_wr | input | 1 | Host writes a character to send |
| host_wdata | input | DW | Character to send |
| tx_pop | input | 1 | Transmitter takes the shown character |
| tx_char | output | DW | Oldest character to send |
| tx_ready | output | 1 | Transmit FIFO holds data |
| tx_fill | output | $clog2(DEPTH+1) | Transmit fill count |
| rx_fifo_clr | input | 1 | Reset the receive FIFO and clear overrun |
| tx_fifo_clr | input | 1 | Reset the transmit FIFO |
| mask_wr | input | 1 | Load the interrupt mask |
| mask_wdata | input | 5 | New mask value |
| rx_level | input | $clog2(DEPTH+1) | Receive threshold |
| tx_level | input | $clog2(DEPTH+1) | Transmit threshold |
| idle_chars | input | TMO_W | Idle timeout in character times |
| irq_mask | output | 5 | Current mask |
| irq_status | output | 6 | Source status bits |
| irq | output | 1 | Interrupt request |

## Verification
Most of the internal state shows up at the ports within one cycle. A fill counter that is off by one moves the level bits one push early or late. A pointer that wraps wrongly changes the order of characters on `host_rdata` or `tx_char` when a full FIFO is drained. A timer that does not restart shows up as an early idle bit after a read. A wrong overrun register shows at once: a character from the discarded push appears in the drained data, or status bit 0 is missing, or it survives reads, or it survives a receive reset. The wait for the fault to appear is never longer than one drain of the FIFO depth.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   // interrupt source positions, shared by the mask and the status word
   localparam int unsigned SRC_RX_OVER  = 0;
   localparam int unsigned SRC_RX_LEVEL = 1;
   localparam int unsigned SRC_RX_IDLE  = 2;
   localparam int unsigned SRC_TX_EMPTY = 3;
   localparam int unsigned SRC_TX_LEVEL = 4;
   localparam int unsigned NUM_SRC      = 5;
   // status-only bit, no mask
   localparam int unsigned ST_RX_AVAIL  = 5;
   localparam int unsigned ST_W         = 6;
   // number of per-character flag bits stored with each receive entry
   localparam int unsigned RX_FLAG_W    = 3;
endpackage

// File: rtl/uif_fifo.sv
module uif_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [W-1:0]                 wdata,
   input  logic                         pop,
   output logic [W-1:0]                 rdata,
   output logic [$clog2(DEPTH+1)-1:0]   fill,
   output logic                         empty,
   output logic                         full,
   output logic                         push_drop
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH+1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt;
   logic          pop_ok, push_ok;

   assign empty  = (cnt == '0);
   assign full   = (cnt == CW'(DEPTH));
   assign pop_ok = pop && !empty && !clr;
   // a full FIFO still takes a push when a read frees a slot in the same cycle
   assign push_ok   = push && !clr && (!full || pop_ok);
   assign push_drop = push && !clr && full && !pop_ok;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
   assign fill  = cnt;
endmodule

// File: rtl/uif_idle_timer.sv
module uif_idle_timer #(
   parameter int unsigned TMO_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             active,
   input  logic             tick,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (restart || !active)  cnt <= '0;
      else if (tick && cnt != '1)   cnt <= cnt + 1'b1;
   end

   assign expired = active && (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/uif_irq_status.sv
module uif_irq_status
   import uart_irq_pkg::*;
#(
   parameter int unsigned CW = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_drop,
   input  logic                rx_clr,
   input  logic [CW-1:0]       rx_fill,
   input  logic [CW-1:0]       tx_fill,
   input  logic [CW-1:0]       rx_level,
   input  logic [CW-1:0]       tx_level,
   input  logic                idle_expired,
   input  logic                mask_wr,
   input  logic [NUM_SRC-1:0]  mask_wdata,
   output logic [NUM_SRC-1:0]  mask,
   output logic [ST_W-1:0]     status,
   output logic                irq
);
   logic                over_q;
   logic [NUM_SRC-1:0]  mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       over_q <= 1'b0;
      else if (rx_clr)  over_q <= 1'b0;
      else if (rx_drop) over_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_wdata;
   end

   always_comb begin
      status               = '0;
      status[SRC_RX_OVER]  = over_q;
      status[SRC_RX_LEVEL] = (rx_fill > rx_level);
      status[SRC_RX_IDLE]  = idle_expired;
      status[SRC_TX_EMPTY] = (tx_fill == '0);
      status[SRC_TX_LEVEL] = (tx_fill < tx_level);
      status[ST_RX_AVAIL]  = (rx_fill != '0);
   end

   assign mask = mask_q;
   assign irq  = |(status[NUM_SRC-1:0] & mask_q);
endmodule

// File: rtl/uart_irq_fifo_unit.sv
module uart_irq_fifo_unit
   import uart_irq_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned TMO_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         char_tick,
   input  logic                         rx_push,
   input  logic [DW-1:0]                rx_char,
   input  logic                         rx_brk,
   input  logic                         rx_par_err,
   input  logic                         rx_frm_err,
   input  logic                         host_rd,
   output logic [DW+3:0]                host_rdata,
   input  logic                         host_wr,
   input  logic [DW-1:0]                host_wdata,
   input  logic                         tx_pop,
   output logic [DW-1:0]                tx_char,
   output logic                         tx_ready,
   output logic [$clog2(DEPTH+1)-1:0]   tx_fill,
   input  logic                         rx_fifo_clr,
   input  logic                         tx_fifo_clr,
   input  logic                         mask_wr,
   input  logic [4:0]                   mask_wdata,
   input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
   input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
   input  logic [TMO_W-1:0]             idle_chars,
   output logic [4:0]                   irq_mask,
   output logic [5:0]                   irq_status,
   output logic                         irq
);
   localparam int unsigned CW   = $clog2(DEPTH+1);
   localparam int unsigned RX_W = DW + RX_FLAG_W;

   generate
      if (DEPTH < 2)   begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (DW < 1)      begin : g_bad_dw    $error("DW must be at least 1"); end
      if (TMO_W < 1)   begin : g_bad_tmo   $error("TMO_W must be at least 1"); end
      if (NUM_SRC != 5 || ST_W != 6) begin : g_bad_pkg $error("status layout mismatch"); end
   endgenerate

   logic [RX_W-1:0] rx_word;
   logic [CW-1:0]   rx_fill_w, tx_fill_w;
   logic            rx_empty, rx_full, rx_drop;
   logic            tx_empty, tx_full, tx_drop;
   logic            idle_exp;

   uif_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rx_fifo_clr),
      .push      (rx_push),
      .wdata     ({rx_brk, rx_par_err, rx_frm_err, rx_char}),
      .pop       (host_rd),
      .rdata     (rx_word),
      .fill      (rx_fill_w),
      .empty     (rx_empty),
      .full      (rx_full),
      .push_drop (rx_drop)
   );

   uif_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tx_fifo_clr),
      .push      (host_wr),
      .wdata     (host_wdata),
      .pop       (tx_pop),
      .rdata     (tx_char),
      .fill      (tx_fill_w),
      .empty     (tx_empty),
      .full      (tx_full),
      .push_drop (tx_drop)
   );

   uif_idle_timer #(.TMO_W(TMO_W)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rx_push || host_rd || rx_fifo_clr),
      .active  (!rx_empty),
      .tick    (char_tick),
      .limit   (idle_chars),
      .expired (idle_exp)
   );

   uif_irq_status #(.CW(CW)) u_stat (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_drop      (rx_drop),
      .rx_clr       (rx_fifo_clr),
      .rx_fill      (rx_fill_w),
      .tx_fill      (tx_fill_w),
      .rx_level     (rx_level),
      .tx_level     (tx_level),
      .idle_expired (idle_exp),
      .mask_wr      (mask_wr),
      .mask_wdata   (mask_wdata),
      .mask         (irq_mask),
      .status       (irq_status),
      .irq          (irq)
   );

   assign host_rdata = rx_empty ? '0 : {1'b1, rx_word};
   assign tx_fill    = tx_fill_w;
   assign tx_ready   = !tx_empty;
endmodule

// File: rtl/uif_checker.sv
module uif_checker #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       rx_fifo_clr,
   input logic                       tx_fifo_clr,
   input logic [$clog2(DEPTH+1)-1:0] tx_fill,
   input logic [DW+3:0]              host_rdata,
   input logic [5:0]                 irq_status,
   input logic [4:0]                 irq_mask,
   input logic                       irq,
   input logic                       tx_ready
);
   assert_over_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status[0] && !rx_fifo_clr) |=> irq_status[0]);

   assert_over_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fifo_clr |=> !irq_status[0]);

   assert_valid_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[DW+3] == irq_status[5]);

   assert_idle_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_status[2] |-> irq_status[5]);

   assert_ready_vs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready == !irq_status[3]);

   assert_tx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_clr |=> (tx_fill == '0));

   assert_no_overfill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fill <= ($clog2(DEPTH+1))'(DEPTH));

   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_mask != '0));
endmodule

bind uart_irq_fifo_unit uif_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_fifo_clr (rx_fifo_clr),
   .tx_fifo_clr (tx_fifo_clr),
   .tx_fill     (tx_fill),
   .host_rdata  (host_rdata),
   .irq_status  (irq_status),
   .irq_mask    (irq_mask),
   .irq         (irq),
   .tx_ready    (tx_ready)
);

// File: tb/uart_irq_fifo_unit_test.sv
module uart_irq_fifo_unit_test;
   localparam int PERIOD = 10;
   localparam int DW     = 8;
   localparam int DEPTH  = 16;
   localparam int TMO_W  = 4;
   localparam int CW     = $clog2(DEPTH+1);

   logic clk = 0, rst_n = 0;
   logic char_tick = 0, rx_push = 0, rx_brk = 0, rx_par_err = 0, rx_frm_err = 0;
   logic [DW-1:0] rx_char = '0, host_wdata = '0, tx_char;
   logic host_rd = 0, host_wr = 0, tx_pop = 0, tx_ready, rx_fifo_clr = 0, tx_fifo_clr = 0;
   logic mask_wr = 0, irq;
   logic [4:0] mask_wdata = '0, irq_mask;
   logic [5:0] irq_status;
   logic [DW+3:0] host_rdata;
   logic [CW-1:0] tx_fill, rx_level = CW'(8), tx_level = '0;
   logic [TMO_W-1:0] idle_chars = '0;

   int checks = 0, bad = 0;
   bit finished = 0;

   always #(PERIOD/2) clk = ~clk;

   uart_irq_fifo_unit #(.DW(DW), .DEPTH(DEPTH), .TMO_W(TMO_W)) uut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rx_in(logic [7:0] c, logic b, logic p, logic f);
      @(negedge clk); rx_push = 1; rx_char = c; rx_brk = b; rx_par_err = p; rx_frm_err = f;
      @(negedge clk); rx_push = 0; rx_brk = 0; rx_par_err = 0; rx_frm_err = 0;
   endtask
   task automatic rd_one();
      @(negedge clk); host_rd = 1; @(negedge clk); host_rd = 0;
   endtask
   task automatic tx_in(logic [7:0] c);
      @(negedge clk); host_wr = 1; host_wdata = c; @(negedge clk); host_wr = 0;
   endtask
   task automatic tx_out();
      @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
   endtask
   task automatic tick();
      @(negedge clk); char_tick = 1; @(negedge clk); char_tick = 0;
   endtask
   task automatic clr_rx();
      @(negedge clk); rx_fifo_clr = 1; @(negedge clk); rx_fifo_clr = 0;
   endtask
   task automatic clr_tx();
      @(negedge clk); tx_fifo_clr = 1; @(negedge clk); tx_fifo_clr = 0;
   endtask
   task automatic set_mask(logic [4:0] m);
      @(negedge clk); mask_wr = 1; mask_wdata = m; @(negedge clk); mask_wr = 0;
   endtask

   task automatic t_reset();
      chk("R1 tx_fill", 32'(tx_fill), 0);
      chk("R1 mask", 32'(irq_mask), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 status", 32'(irq_status), 32'h08);
      chk("R1 rdata", 32'(host_rdata), 0);
   endtask

   task automatic t_rx_word();
      rx_in(8'h5A, 1, 0, 1);
      rx_in(8'h33, 0, 1, 0);
      chk("R2 first entry", 32'(host_rdata), 32'hD5A);
      chk("R8 avail", 32'(irq_status[5]), 1);
      rd_one();
      chk("R2 second entry", 32'(host_rdata), 32'hA33);
      rd_one();
      chk("R2 empty read", 32'(host_rdata), 0);
      chk("R8 avail off", 32'(irq_status[5]), 0);
   endtask

   task automatic t_rx_level();
      for (int i = 0; i < 8; i++) rx_in(8'(i), 0, 0, 0);
      chk("R4 at level", 32'(irq_status[1]), 0);
      rx_in(8'h08, 0, 0, 0);
      chk("R4 above level", 32'(irq_status[1]), 1);
      rd_one();
      chk("R4 back at level", 32'(irq_status[1]), 0);
      clr_rx();
   endtask

   task automatic t_overrun();
      for (int i = 0; i < DEPTH; i++) rx_in(8'(8'h20 + i), 0, 0, 0);
      chk("R3 no overrun when full", 32'(irq_status[0]), 0);
      rx_in(8'hAA, 0, 0, 0);
      chk("R3 overrun set", 32'(irq_status[0]), 1);
      for (int i = 0; i < DEPTH; i++) begin
         chk("R3 kept data", 32'(host_rdata), 32'(12'h800 | (8'h20 + i)));
         rd_one();
      end
      chk("R3 dropped char absent", 32'(host_rdata), 0);
      chk("R3 sticky after reads", 32'(irq_status[0]), 1);
      clr_rx();
      chk("R3 cleared by rx reset", 32'(irq_status[0]), 0);
   endtask

   task automatic t_idle();
      idle_chars = 4'd2;
      rx_in(8'h41, 0, 0, 0);
      tick();
      chk("R5 one tick", 32'(irq_status[2]), 0);
      tick();
      chk("R5 two ticks", 32'(irq_status[2]), 1);
      rx_in(8'h42, 0, 0, 0);
      chk("R5 restart on push", 32'(irq_status[2]), 0);
      tick(); rd_one(); tick();
      chk("R5 restart on read", 32'(irq_status[2]), 0);
      tick();
      chk("R5 expires again", 32'(irq_status[2]), 1);
      rd_one();
      chk("R5 off when empty", 32'(irq_status[2]), 0);
      idle_chars = '0;
      rx_in(8'h43, 0, 0, 0);
      for (int i = 0; i < 5; i++) tick();
      chk("R5 disabled by zero", 32'(irq_status[2]), 0);
      clr_rx();
   endtask

   task automatic t_tx();
      tx_level = CW'(4);
      for (int i = 0; i < 3; i++) tx_in(8'(8'h60 + i));
      chk("R7 fill 3", 32'(tx_fill), 3);
      chk("R6 not empty", 32'(irq_status[3]), 0);
      chk("R6 below level", 32'(irq_status[4]), 1);
      tx_in(8'h63);
      chk("R6 at level", 32'(irq_status[4]), 0);
      for (int i = 4; i < DEPTH; i++) tx_in(8'(8'h60 + i));
      tx_in(8'hEE);
      chk("R7 full write dropped", 32'(tx_fill), DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
         chk("R7 order", 32'(tx_char), 32'(8'h60 + i));
         tx_out();
      end
      chk("R7 drained", 32'(tx_fill), 0);
      chk("R6 empty", 32'(irq_status[3]), 1);
      chk("R6 ready low", 32'(tx_ready), 0);
      tx_level = '0;
   endtask

   task automatic t_mask();
      chk("R9 unmasked empty", 32'(irq), 0);
      set_mask(5'b01000);
      chk("R9 mask readback", 32'(irq_mask), 32'h08);
      chk("R9 tx empty irq", 32'(irq), 1);
      set_mask(5'b00001);
      chk("R9 overrun masked idle", 32'(irq), 0);
      for (int i = 0; i <= DEPTH; i++) rx_in(8'(i), 0, 0, 0);
      chk("R9 overrun irq", 32'(irq), 1);
      clr_rx();
      chk("R9 irq drops", 32'(irq), 0);
      set_mask('0);
   endtask

   task automatic t_clear_split();
      tx_in(8'h71); tx_in(8'h72);
      rx_in(8'h11, 0, 0, 0);
      clr_rx();
      chk("R10 rx cleared", 32'(irq_status[5]), 0);
      chk("R10 tx kept", 32'(tx_fill), 2);
      rx_in(8'h12, 0, 0, 0);
      clr_tx();
      chk("R10 tx cleared", 32'(tx_fill), 0);
      chk("R10 rx kept", 32'(host_rdata), 32'h812);
      clr_rx();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_rx_word();
      t_rx_level();
      t_overrun();
      t_idle();
      t_tx();
      t_mask();
      t_clear_split();
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      if (!finished) begin
         checks++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule